// File: doc/BRIEF.md
# Register-Block Memory Mover

This sequencer copies a run of data between a 32-entry by 32-bit register file and byte-addressed memory. One start pulse gives it an operation, a base address, a first register and a length. It then issues memory requests one at a time until the run is finished. Five operations exist. Two word-block forms fill or drain every register from the first one through register 31. Two byte-string forms move a given number of bytes. An indexed string load takes its length from a separate count input and refuses to run when its address registers lie inside the span it would overwrite.

The memory side is a valid/ready pair. `mem_req` is the valid and `mem_ack` is the ready. While `mem_req` is high, the address, direction, size and write data stay unchanged until a cycle in which `mem_ack` is high. That cycle completes the transfer, and read data must be presented on `mem_rdata` in that same cycle. Back-pressure is applied by holding `mem_ack` low for as long as needed. The sequencer never has more than one request open, and an ack while `mem_req` is low is ignored. The register file is used through one combinational read port and one write port.

Top module: `regmove_seq`

## Requirements
- R1: Op code 0 (word-block load) writes registers first..31 in rising order. Each register receives the big-endian word at base + 4k, where k counts from 0.
- R2: Op code 1 (word-block store) writes registers first..31 to addresses base + 4k as big-endian words. Each uses one word-size request.
- R3: With `swap_en` high, the word-block forms reverse the byte order of each word. The string forms (op codes 2, 3, 4) never swap bytes.
- R4: The string forms (op 2 load, op 3 store, op 4 indexed load) move whole words while more than 3 bytes remain. The register number steps by one after each word and wraps from 31 to 0.
- R5: A string load with 1 to 3 bytes left fills the current register with those bytes at bits 31:24, 23:16 and 15:8 in address order. All remaining bits are zero. Each byte is fetched by a byte-size request, and the address steps by 1 per byte.
- R6: A string store with 1 to 3 bytes left writes bits 31:24, 23:16 and 15:8 of the current register, in that order, to successive byte addresses. Each byte travels on `mem_wdata[7:0]`.
- R7: With `addr32` high, every address increment keeps only its low 32 bits, so the upper address bits become zero. With `addr32` low, the full address width carries.
- R8: A string run whose length is zero, and any op code above 4, touches neither memory nor registers. Such a start gives a `done` pulse in the next cycle.
- R9: Op 4 uses `idx_len` as its length. For a nonzero length it covers (len+3)/4 registers from `first_reg`, counted modulo 32. If `idx_ra` is nonzero and lies in that span, or `idx_rb` lies in it, `exc` pulses in the next cycle and nothing is transferred.
- R10: At most one memory request is open. Address, direction and size stay stable until acked, and the sequencer advances only on an ack.
- R11: `done` is high for exactly one cycle, in the cycle after the ack of the final transfer. `busy` is high while a run is in progress, and a start while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| op | input | 3 | 0 block load, 1 block store, 2 string load, 3 string store, 4 indexed string load |
| base_addr | input | AW | First memory address |
| first_reg | input | 5 | First register number |
| str_len | input | LEN_W | Byte length for op 2 and op 3 |
| idx_len | input | LEN_W | Byte length for op 4 |
| idx_ra | input | 5 | First address register of op 4 (0 means none) |
| idx_rb | input | 5 | Second address register of op 4 |
| addr32 | input | 1 | Wrap address increments to 32 bits |
| swap_en | input | 1 | Byte-reverse words of the block forms |
| mem_req | output | 1 | Memory request valid |
| mem_ack | input | 1 | Memory request accepted and completed |
| mem_we | output | 1 | 1 write, 0 read |
| mem_size | output | 1 | 1 word, 0 byte |
| mem_addr | output | AW | Request address |
| mem_wdata | output | 32 | Write data (byte in bits 7:0) |
| mem_rdata | input | 32 | Read data, valid with ack (byte in bits 7:0) |
| rf_raddr | output | 5 | Register read index |
| rf_rdata | input | 32 | Register read data |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 5 | Register write index |
| rf_wdata | output | 32 | Register write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| exc | output | 1 | One-cycle invalid-form pulse |

## Verification
The block forms are started from first registers 0, 13, 30 and 31, each with and without swap. This separates the stop at register 31 and the byte order. String lengths 0 through 11 are started near register 31, which covers the zero case, the pure-tail case, the word-plus-tail case and the wrap to register 0, while the swap input toggles to show it has no effect. The indexed load is swept across every value of each address register for several lengths. This separates in-span from out-of-span registers, including the span that wraps past 31 and the exemption of a zero first address register. Memory acks arrive after varying delays, and addresses just below a 32-bit boundary show whether increments wrap or carry.

// File: rtl/regmove_pkg.sv
package regmove_pkg;
  typedef enum logic [2:0] {
    OP_BLK_LOAD  = 3'd0,
    OP_BLK_STORE = 3'd1,
    OP_STR_LOAD  = 3'd2,
    OP_STR_STORE = 3'd3,
    OP_STR_LOADX = 3'd4
  } mv_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_MOVE = 1'b1
  } mv_state_e;
endpackage

// File: rtl/regmove_span.sv
module regmove_span #(
  parameter int LEN_W = 7
) (
  input  logic [4:0]       first_i,
  input  logic [LEN_W-1:0] cnt_i,
  input  logic [4:0]       ra_i,
  input  logic [4:0]       rb_i,
  output logic             hit_o
);
  localparam int NW = LEN_W + 1;

  logic [NW-1:0] nregs;
  logic [4:0]    dist_a;
  logic [4:0]    dist_b;

  // registers covered, rounded up; distance taken modulo 32 handles wrap
  assign nregs  = (NW'(cnt_i) + NW'(3)) >> 2;
  assign dist_a = ra_i - first_i;
  assign dist_b = rb_i - first_i;
  assign hit_o  = ((ra_i != 5'd0) && (NW'(dist_a) < nregs)) ||
                  (NW'(dist_b) < nregs);
endmodule

// File: rtl/regmove_addr_step.sv
module regmove_addr_step #(
  parameter int AW = 64
) (
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    inc_i,
  input  logic          wrap32_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] sum;
  assign sum = addr_i + AW'(inc_i);

  generate
    if (AW > 32) begin : g_wide
      assign addr_o = wrap32_i ? {{(AW-32){1'b0}}, sum[31:0]} : sum;
    end else begin : g_narrow
      logic wrap_unused;
      assign wrap_unused = wrap32_i;
      assign addr_o = sum;
    end
  endgenerate
endmodule

// File: rtl/regmove_bswap.sv
module regmove_bswap (
  input  logic [31:0] word_i,
  input  logic        swap_i,
  output logic [31:0] word_o
);
  logic [31:0] rev;
  for (genvar b = 0; b < 4; b++) begin : g_lane
    assign rev[8*b +: 8] = word_i[8*(3-b) +: 8];
  end
  assign word_o = swap_i ? rev : word_i;
endmodule

// File: rtl/regmove_tail.sv
module regmove_tail (
  input  logic [31:0] acc_i,
  input  logic [7:0]  byte_i,
  input  logic [1:0]  pos_i,
  input  logic [31:0] src_i,
  output logic [31:0] acc_o,
  output logic [7:0]  byte_o
);
  logic [4:0] sh;
  always_comb begin
    case (pos_i)
      2'd0:    sh = 5'd24;
      2'd1:    sh = 5'd16;
      default: sh = 5'd8;
    endcase
  end
  assign acc_o  = acc_i | ({24'd0, byte_i} << sh);
  assign byte_o = 8'(src_i >> sh);
endmodule

// File: rtl/regmove_seq.sv
module regmove_seq
  import regmove_pkg::*;
#(
  parameter int AW    = 64,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic [AW-1:0]    base_addr,
  input  logic [4:0]       first_reg,
  input  logic [LEN_W-1:0] str_len,
  input  logic [LEN_W-1:0] idx_len,
  input  logic [4:0]       idx_ra,
  input  logic [4:0]       idx_rb,
  input  logic             addr32,
  input  logic             swap_en,
  output logic             mem_req,
  input  logic             mem_ack,
  output logic             mem_we,
  output logic             mem_size,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic [4:0]       rf_raddr,
  input  logic [31:0]      rf_rdata,
  output logic             rf_we,
  output logic [4:0]       rf_waddr,
  output logic [31:0]      rf_wdata,
  output logic             busy,
  output logic             done,
  output logic             exc
);
  localparam int LW = ((LEN_W > 7) ? LEN_W : 7) + 1;

  mv_state_e     st_q;
  logic          load_q, swap_q, wrap_q, done_q, exc_q;
  logic [AW-1:0] addr_q;
  logic [4:0]    reg_q;
  logic [LW-1:0] left_q;
  logic [31:0]   acc_q;
  logic [1:0]    pos_q;

  // start decode
  logic [5:0]    blk_regs;
  logic [LW-1:0] start_left;
  logic          start_load, start_swap, start_fault, span_hit;

  assign blk_regs = 6'd32 - {1'b0, first_reg};

  regmove_span #(.LEN_W(LEN_W)) u_span (
    .first_i(first_reg), .cnt_i(idx_len), .ra_i(idx_ra), .rb_i(idx_rb),
    .hit_o(span_hit)
  );

  always_comb begin
    start_left  = '0;
    start_load  = 1'b0;
    start_swap  = 1'b0;
    start_fault = 1'b0;
    case (op)
      OP_BLK_LOAD: begin
        start_left = LW'({blk_regs, 2'b00});
        start_load = 1'b1;
        start_swap = swap_en;
      end
      OP_BLK_STORE: begin
        start_left = LW'({blk_regs, 2'b00});
        start_swap = swap_en;
      end
      OP_STR_LOAD: begin
        start_left = LW'(str_len);
        start_load = 1'b1;
      end
      OP_STR_STORE: begin
        start_left = LW'(str_len);
      end
      OP_STR_LOADX: begin
        start_left  = LW'(idx_len);
        start_load  = 1'b1;
        start_fault = (idx_len != '0) && span_hit;
      end
      default: start_left = '0;
    endcase
  end

  // datapath pieces
  logic          word_ph, last_xfer;
  logic [AW-1:0] addr_nx;
  logic [31:0]   rd_word, wr_word, acc_nx;
  logic [7:0]    st_byte;

  assign word_ph   = left_q >= LW'(4);
  assign last_xfer = word_ph ? (left_q == LW'(4)) : (left_q == LW'(1));

  regmove_addr_step #(.AW(AW)) u_step (
    .addr_i(addr_q), .inc_i(word_ph ? 3'd4 : 3'd1), .wrap32_i(wrap_q),
    .addr_o(addr_nx)
  );

  regmove_bswap u_rd_swap (.word_i(mem_rdata), .swap_i(swap_q), .word_o(rd_word));
  regmove_bswap u_wr_swap (.word_i(rf_rdata),  .swap_i(swap_q), .word_o(wr_word));

  regmove_tail u_tail (
    .acc_i(acc_q), .byte_i(mem_rdata[7:0]), .pos_i(pos_q), .src_i(rf_rdata),
    .acc_o(acc_nx), .byte_o(st_byte)
  );

  // sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      load_q <= 1'b0;
      swap_q <= 1'b0;
      wrap_q <= 1'b0;
      done_q <= 1'b0;
      exc_q  <= 1'b0;
      addr_q <= '0;
      reg_q  <= '0;
      left_q <= '0;
      acc_q  <= '0;
      pos_q  <= '0;
    end else begin
      done_q <= 1'b0;
      exc_q  <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            if (start_fault) begin
              exc_q <= 1'b1;
            end else if (start_left == '0) begin
              done_q <= 1'b1;
            end else begin
              st_q   <= ST_MOVE;
              load_q <= start_load;
              swap_q <= start_swap;
              wrap_q <= addr32;
              addr_q <= base_addr;
              reg_q  <= first_reg;
              left_q <= start_left;
              acc_q  <= '0;
              pos_q  <= '0;
            end
          end
        end
        default: begin
          if (mem_ack) begin
            addr_q <= addr_nx;
            if (word_ph) begin
              reg_q  <= reg_q + 5'd1;
              left_q <= left_q - LW'(4);
            end else begin
              acc_q  <= acc_nx;
              pos_q  <= pos_q + 2'd1;
              left_q <= left_q - LW'(1);
            end
            if (last_xfer) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign busy      = (st_q == ST_MOVE);
  assign done      = done_q;
  assign exc       = exc_q;
  assign mem_req   = busy;
  assign mem_we    = ~load_q;
  assign mem_size  = word_ph;
  assign mem_addr  = addr_q;
  assign mem_wdata = word_ph ? wr_word : {24'd0, st_byte};
  assign rf_raddr  = reg_q;
  assign rf_waddr  = reg_q;
  assign rf_we     = busy && mem_ack && load_q && (word_ph || (left_q == LW'(1)));
  assign rf_wdata  = word_ph ? rd_word : acc_nx;

  // checks
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size)))
    else $error("request changed before ack");

  assert_exc_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> (!mem_req && !rf_we))
    else $error("transfer alongside exception");

  assert_done_exc_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && exc))
    else $error("done and exc together");

  assert_done_after_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(busy)) |-> $past(mem_ack))
    else $error("done without a final ack");

  generate
    if (AW > 32) begin : g_wrap_chk
      assert_addr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req && mem_ack) && wrap_q) |-> (mem_addr[AW-1:32] == '0))
        else $error("address increment not wrapped");
    end
  endgenerate
endmodule

// File: tb/regmove_seq_test.sv
module regmove_seq_test;
  localparam int AW = 64;
  localparam int LEN_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             start = 1'b0;
  logic [2:0]       op_i = '0;
  logic [AW-1:0]    base_addr = '0;
  logic [4:0]       first_reg = '0;
  logic [LEN_W-1:0] str_len = '0, idx_len = '0;
  logic [4:0]       idx_ra = '0, idx_rb = '0;
  logic             addr32 = 1'b0, swap_en = 1'b0;
  logic             mem_req, mem_we, mem_size;
  logic             mem_ack;
  logic [AW-1:0]    mem_addr;
  logic [31:0]      mem_wdata, mem_rdata;
  logic [4:0]       rf_raddr, rf_waddr;
  logic [31:0]      rf_rdata, rf_wdata;
  logic             rf_we, busy, done, exc;

  regmove_seq #(.AW(AW), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .base_addr(base_addr),
    .first_reg(first_reg), .str_len(str_len), .idx_len(idx_len),
    .idx_ra(idx_ra), .idx_rb(idx_rb), .addr32(addr32), .swap_en(swap_en),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .busy(busy), .done(done), .exc(exc)
  );

  // environment models
  logic [31:0]   rf_m [32];
  logic [7:0]    mem_m [256];
  logic [AW-1:0] alog [200];
  int            alog_n = 0;
  int            hold_viol = 0;
  logic          init_req = 1'b0;
  logic [31:0]   seed = 32'h5;
  int            lat = 0, wcnt = 0;
  logic          held = 1'b0;
  logic [AW-1:0] held_addr = '0;
  logic [7:0]    bi;

  assign bi = mem_addr[7:0];
  assign rf_rdata = rf_m[rf_raddr];

  function automatic logic [31:0] rf_init(input logic [31:0] s, input int i);
    return (32'h9E3779B9 * 32'(i + 1)) ^ (s * 32'h01000193);
  endfunction

  function automatic logic [7:0] mem_init(input logic [31:0] s, input int j);
    return 8'(32'(j * 37) + s * 32'd11 + 32'd5);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      wcnt      <= 0;
      held      <= 1'b0;
    end else begin
      if (init_req) begin
        for (int i = 0; i < 32; i++) rf_m[i] <= rf_init(seed, i);
        for (int j = 0; j < 256; j++) mem_m[j] <= mem_init(seed, j);
        alog_n    <= 0;
        hold_viol <= 0;
      end
      if (mem_req && !mem_ack) begin
        if (held && mem_addr != held_addr) hold_viol <= hold_viol + 1;
        held      <= 1'b1;
        held_addr <= mem_addr;
      end else begin
        held <= 1'b0;
      end
      if (mem_ack) begin
        mem_ack <= 1'b0;
      end else if (mem_req) begin
        if (wcnt >= lat) begin
          alog[alog_n] <= mem_addr;
          alog_n <= alog_n + 1;
          if (mem_we) begin
            if (mem_size) begin
              mem_m[bi]          <= mem_wdata[31:24];
              mem_m[8'(bi + 1)]  <= mem_wdata[23:16];
              mem_m[8'(bi + 2)]  <= mem_wdata[15:8];
              mem_m[8'(bi + 3)]  <= mem_wdata[7:0];
            end else begin
              mem_m[bi] <= mem_wdata[7:0];
            end
          end else begin
            mem_rdata <= mem_size ?
              {mem_m[bi], mem_m[8'(bi + 1)], mem_m[8'(bi + 2)], mem_m[8'(bi + 3)]} :
              {24'd0, mem_m[bi]};
          end
          mem_ack <= 1'b1;
          wcnt    <= 0;
          lat     <= (lat == 2) ? 0 : lat + 1;
        end else begin
          wcnt <= wcnt + 1;
        end
      end
      if (rf_we) rf_m[rf_waddr] <= rf_wdata;
    end
  end

  // bookkeeping
  int nchk = 0, nerr = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference state
  logic [31:0]   rf_x [32];
  logic [7:0]    mem_x [256];
  logic [AW-1:0] elog [200];
  int            elog_n;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input int inc, input bit w32);
    logic [AW-1:0] s;
    s = a + AW'(inc);
    if (w32) s[AW-1:32] = '0;
    return s;
  endfunction

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic run(input int op, input logic [AW-1:0] base, input int first,
                     input int slen, input int xlen, input int ra, input int rb,
                     input bit swp, input bit w32, input bit poke,
                     input string tag, input string atag);
    logic [AW-1:0] a;
    logic [31:0]   w;
    logic [7:0]    k;
    int nb, r, sh, bad, bix;
    bit ex_exc, zero, fired, prev_ack;

    @(negedge clk);
    seed = seed + 32'h1357;
    init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
    for (int i = 0; i < 32; i++) rf_x[i] = rf_init(seed, i);
    for (int j = 0; j < 256; j++) mem_x[j] = mem_init(seed, j);
    elog_n = 0;
    a = base;
    ex_exc = 1'b0;
    zero = 1'b0;

    case (op)
      0, 1: begin
        for (int rr = first; rr < 32; rr++) begin
          k = a[7:0];
          if (op == 0) begin
            w = {mem_x[k], mem_x[8'(k + 1)], mem_x[8'(k + 2)], mem_x[8'(k + 3)]};
            rf_x[rr] = swp ? bswap(w) : w;
          end else begin
            w = swp ? bswap(rf_x[rr]) : rf_x[rr];
            mem_x[k] = w[31:24]; mem_x[8'(k + 1)] = w[23:16];
            mem_x[8'(k + 2)] = w[15:8]; mem_x[8'(k + 3)] = w[7:0];
          end
          elog[elog_n] = a; elog_n++;
          a = step(a, 4, w32);
        end
      end
      2, 3, 4: begin
        nb = (op == 4) ? xlen : slen;
        if (op == 4 && nb != 0) begin
          for (int j = 0; j < (nb + 3) / 4; j++) begin
            r = (first + j) % 32;
            if ((ra != 0 && r == ra) || r == rb) ex_exc = 1'b1;
          end
        end
        zero = (nb == 0);
        if (!ex_exc) begin
          r = first;
          while (nb > 3) begin
            k = a[7:0];
            if (op == 3) begin
              mem_x[k] = rf_x[r][31:24]; mem_x[8'(k + 1)] = rf_x[r][23:16];
              mem_x[8'(k + 2)] = rf_x[r][15:8]; mem_x[8'(k + 3)] = rf_x[r][7:0];
            end else begin
              rf_x[r] = {mem_x[k], mem_x[8'(k + 1)], mem_x[8'(k + 2)], mem_x[8'(k + 3)]};
            end
            elog[elog_n] = a; elog_n++;
            a = step(a, 4, w32);
            r = (r + 1) % 32;
            nb -= 4;
          end
          if (nb > 0) begin
            if (op != 3) rf_x[r] = 32'd0;
            sh = 24;
            while (nb > 0) begin
              k = a[7:0];
              if (op == 3) mem_x[k] = 8'(rf_x[r] >> sh);
              else rf_x[r] = rf_x[r] | (32'(mem_x[k]) << sh);
              elog[elog_n] = a; elog_n++;
              a = step(a, 1, w32);
              sh -= 8;
              nb--;
            end
          end
        end
      end
      default: zero = 1'b1;
    endcase

    op_i = 3'(op); base_addr = base; first_reg = 5'(first);
    str_len = LEN_W'(slen); idx_len = LEN_W'(xlen);
    idx_ra = 5'(ra); idx_rb = 5'(rb); swap_en = swp; addr32 = w32;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    fired = 1'b0;
    prev_ack = 1'b0;
    for (int c = 0; c < 3000 && !fired; c++) begin
      if (done || exc) begin
        fired = 1'b1;
      end else begin
        if (poke && c == 2) begin
          op_i = 3'd1; first_reg = 5'd0; start = 1'b1;
        end else begin
          start = 1'b0;
        end
        prev_ack = mem_ack;
        @(negedge clk);
      end
    end
    start = 1'b0;

    check(fired, "R11", "completion pulse seen", 64'(fired), 64'd1);
    check(exc == ex_exc, ex_exc ? "R9" : tag, "exception flag", 64'(exc), 64'(ex_exc));
    check(done == !ex_exc, tag, "done flag", 64'(done), 64'(!ex_exc));
    if (!zero && !ex_exc)
      check(prev_ack, "R11", "done one cycle after final ack", 64'(prev_ack), 64'd1);
    @(negedge clk);
    check(!done && !exc && !busy, "R11", "single-cycle pulse, idle after",
          {61'd0, done, exc, busy}, 64'd0);

    bad = 0; bix = 0;
    for (int i = 0; i < 32; i++)
      if (rf_m[i] !== rf_x[i]) begin if (bad == 0) bix = i; bad++; end
    check(bad == 0, tag, "register file contents", 64'(rf_m[bix]), 64'(rf_x[bix]));
    bad = 0; bix = 0;
    for (int j = 0; j < 256; j++)
      if (mem_m[j] !== mem_x[j]) begin if (bad == 0) bix = j; bad++; end
    check(bad == 0, tag, "memory contents", 64'(mem_m[bix]), 64'(mem_x[bix]));
    check(alog_n == elog_n, tag, "request count", 64'(alog_n), 64'(elog_n));
    bad = 0; bix = 0;
    for (int i = 0; i < elog_n && i < alog_n; i++)
      if (alog[i] !== elog[i]) begin if (bad == 0) bix = i; bad++; end
    check(bad == 0, atag, "request address sequence", alog[bix], elog[bix]);
    check(hold_viol == 0, "R10", "request held until ack", 64'(hold_viol), 64'd0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R11 watchdog expired: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : main
    int firsts[4];
    int xls[6];
    firsts = '{0, 13, 30, 31};
    xls = '{0, 1, 4, 5, 8, 13};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !exc && !mem_req && !rf_we, "R11", "reset state",
          {59'd0, busy, done, exc, mem_req, rf_we}, 64'd0);

    // R1 / R2 / R3: block forms
    foreach (firsts[f]) begin
      for (int s = 0; s < 2; s++) begin
        run(0, 64'h10 + 64'(4 * firsts[f]), firsts[f], 0, 0, 0, 0, s[0], 1'b0, 1'b0,
            s[0] ? "R3" : "R1", "R1");
        run(1, 64'h08 + 64'(4 * firsts[f]), firsts[f], 0, 0, 0, 0, s[0], 1'b0, 1'b0,
            s[0] ? "R3" : "R2", "R2");
      end
    end

    // R4 / R5 / R6 / R8: string forms, swap input must be ignored (R3)
    for (int len = 0; len < 12; len++) begin
      run(2, 64'h21, 29, len, 0, 0, 0, len[0], 1'b0, 1'b0,
          (len == 0) ? "R8" : (len < 4) ? "R5" : "R4", "R5");
      run(3, 64'h43, 30, len, 0, 0, 0, len[1], 1'b0, 1'b0,
          (len == 0) ? "R8" : "R6", "R6");
    end

    // R8: unused op code
    run(6, 64'h0, 3, 9, 9, 0, 0, 1'b0, 1'b0, 1'b0, "R8", "R8");

    // R7: 32-bit wrap versus full carry
    run(0, 64'h0000_0003_FFFF_FFF4, 28, 0, 0, 0, 0, 1'b0, 1'b1, 1'b0, "R7", "R7");
    run(0, 64'h0000_0003_FFFF_FFF4, 28, 0, 0, 0, 0, 1'b0, 1'b0, 1'b0, "R7", "R7");
    run(3, 64'h0000_0001_FFFF_FFFE, 5, 7, 0, 0, 0, 1'b0, 1'b1, 1'b0, "R7", "R7");
    run(2, 64'h0000_0001_FFFF_FFFD, 9, 6, 0, 0, 0, 1'b0, 1'b0, 1'b0, "R7", "R7");

    // R9: indexed form, span check across every register value
    foreach (xls[x]) begin
      for (int v = 0; v < 32; v++) begin
        run(4, 64'h80, 30, 2, xls[x], v, 12, 1'b0, 1'b0, 1'b0, "R9", "R9");
        run(4, 64'h90, 30, 2, xls[x], 0, v, 1'b0, 1'b0, 1'b0, "R9", "R9");
      end
    end

    // R11: start while busy is ignored
    run(0, 64'h0, 0, 0, 0, 0, 0, 1'b1, 1'b0, 1'b1, "R11", "R11");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule